// File: doc/BRIEF.md
# Per-Input Circular Page Recorder

This block controls recording for one signal input of a transient capture memory. It hands out write requests for whole 8 KiB pages. The pages cycle through a window of memory that firmware chooses for this input, from a start page to an end page. When the end page has been written, the next request goes back to the start page, so the ring has no gap. Each request carries the page's byte address and the sample sequence number (SSN) of the first sample in the page. The SSN is the block sequence number multiplied by the transform length, so a page begins only on a sample whose SSN is a multiple of the samples-per-page count. This keeps page boundaries aligned with processing blocks.

The controller has two states, stop and record, and a reset that always leaves it in stop. It moves from stop to record while the shared processing-enable level is high, and it returns to stop when that level falls. A freeze command holds the ring: page writes stop and the captured history stays in memory for readout. While frozen, the block shows where the newest and the oldest pages sit in the ring. An unfreeze command releases the hold, and recording starts again from the start page without clearing memory first. The status outputs give the fixed input index, the recording and frozen flags, a reading flag, a wrapped flag, and a configuration-error flag.

Top module: `recbuf_recorder`

## Requirements
- R1: After reset the block is in stop. It is not frozen, has no accepted window, and has pageReq, stWrapped and stCfgErr all low. stInputIdx shows the INPUT_INDEX parameter.
- R2: A cfgLoad pulse in stop is accepted only when cfgStartAddr and cfgEndAddr both have bits [12:0] equal to zero and cfgEndAddr >= cfgStartAddr. An accepted load clears stCfgErr and places the ring pointer at the start page. A rejected load sets stCfgErr and keeps the previous window. A cfgLoad pulse during record is ignored, and stCfgErr keeps its value.
- R3: In stop, with no freeze pending, an accepted window, procEnable high and no cfgLoad, stRecording rises one cycle after the edge. In record, procEnable low returns the block to stop one cycle later.
- R4: In record, a sampleValid cycle whose sampleSsn has its low log2(SAMPLES_PER_PAGE) bits at zero produces a one-cycle pageReq after the edge. pageAddr is the current page times 8192, and pageSsn equals that sampleSsn. The first page after entering record is the start page.
- R5: After the end page the next page is the start page, and stWrapped then goes high. Entering record or accepting a window clears stWrapped.
- R6: freezeCmd puts the block in stop with stFrozen high, in either state. A freeze in the same cycle as a page-start sample wins, so no page is requested. While frozen, no page is requested and record is not entered.
- R7: newestAddr and newestSsn show the address and SSN of the last requested page. oldestAddr is the current pointer once the ring has wrapped, and the start page before that.
- R8: unfreezeCmd in stop clears stFrozen. Recording then resumes at the start page once procEnable is high.
- R9: stReading is high exactly when the block is frozen and readBusy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| procEnable | input | 1 | Shared processing-enable level |
| cfgLoad | input | 1 | Apply the window bounds pulse |
| cfgStartAddr | input | ADDR_W | Window start byte address |
| cfgEndAddr | input | ADDR_W | Window end byte address (start of last page) |
| freezeCmd | input | 1 | Freeze pulse |
| unfreezeCmd | input | 1 | Unfreeze pulse |
| readBusy | input | 1 | Readout engine is draining this input |
| sampleValid | input | 1 | Sample stream valid |
| sampleSsn | input | SSN_W | SSN of the current sample |
| pageReq | output | 1 | Page write request, one cycle |
| pageAddr | output | ADDR_W | Byte address of the requested page |
| pageSsn | output | SSN_W | SSN of the first sample of the page |
| newestAddr | output | ADDR_W | Address of the last written page |
| newestSsn | output | SSN_W | SSN of the last written page |
| oldestAddr | output | ADDR_W | Address of the oldest page in the ring |
| stRecording | output | 1 | Block is in record |
| stFrozen | output | 1 | Ring is frozen |
| stReading | output | 1 | Frozen ring is being read |
| stWrapped | output | 1 | Ring has completed a full pass |
| stCfgErr | output | 1 | Last window load was rejected |
| stInputIdx | output | 8 | Signal input index |

## Verification
The hardest case to reach is a ring that wraps several times, is then frozen in the same cycle as a page-start sample, and is unfrozen with a new window loaded between the freeze and the restart. A directed sequence sets a three-page window, streams aligned SSNs until the pointer has passed the end page twice, and issues the freeze on a page-start cycle. Random phases then mix freeze and unfreeze pulses, procEnable toggles, and loads of good, misaligned and reversed windows with a gappy sample stream. A cycle-level model in the bench checks every output on every cycle.

// File: rtl/recbuf_pkg.sv
package recbuf_pkg;

  typedef enum logic [0:0] {
    REC_STOP = 1'b0,
    REC_RUN  = 1'b1
  } recState_t;

  // strobes from the controller to the datapath, one cycle each
  typedef struct packed {
    logic loadCfg;    // latch new window bounds
    logic restart;    // rewind pointer to start page
    logic pageWrite;  // issue a page request and advance
  } recStrobe_t;

endpackage

// File: rtl/recbuf_ctrl.sv
module recbuf_ctrl
  import recbuf_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_SHIFT = 13,
  parameter int ALIGN_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              procEnable,
  input  logic              cfgLoad,
  input  logic [ADDR_W-1:0] cfgStartAddr,
  input  logic [ADDR_W-1:0] cfgEndAddr,
  input  logic              freezeCmd,
  input  logic              unfreezeCmd,
  input  logic              sampleValid,
  input  logic [ALIGN_W-1:0] sampleSsnLow,
  output recStrobe_t        strobe,
  output logic              recording,
  output logic              frozen,
  output logic              cfgErr
);

  recState_t state, nextState;
  logic      cfgValid, nextCfgValid;
  logic      nextFrozen, nextCfgErr;
  logic      cfgOk;
  logic      pageStart;

  assign cfgOk = (cfgStartAddr[PAGE_SHIFT-1:0] == '0) &&
                 (cfgEndAddr[PAGE_SHIFT-1:0] == '0) &&
                 (cfgEndAddr >= cfgStartAddr);

  assign pageStart = sampleValid && (sampleSsnLow == '0);

  always_comb begin
    strobe       = '0;
    nextState    = state;
    nextFrozen   = frozen;
    nextCfgValid = cfgValid;
    nextCfgErr   = cfgErr;
    if (state == REC_STOP) begin
      if (cfgLoad) begin
        if (cfgOk) begin
          strobe.loadCfg = 1'b1;
          nextCfgValid   = 1'b1;
          nextCfgErr     = 1'b0;
        end else begin
          nextCfgErr = 1'b1;
        end
      end
      if (freezeCmd) begin
        nextFrozen = 1'b1;
      end else if (unfreezeCmd) begin
        nextFrozen = 1'b0;
      end else if (!frozen && cfgValid && procEnable && !cfgLoad) begin
        nextState      = REC_RUN;
        strobe.restart = 1'b1;
      end
    end else begin
      if (freezeCmd) begin
        nextState  = REC_STOP;
        nextFrozen = 1'b1;
      end else if (!procEnable) begin
        nextState = REC_STOP;
      end else if (pageStart) begin
        strobe.pageWrite = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= REC_STOP;
      frozen   <= 1'b0;
      cfgValid <= 1'b0;
      cfgErr   <= 1'b0;
    end else begin
      state    <= nextState;
      frozen   <= nextFrozen;
      cfgValid <= nextCfgValid;
      cfgErr   <= nextCfgErr;
    end
  end

  assign recording = (state == REC_RUN);

  // R6
  frozen_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> (state == REC_STOP));

  // R6
  no_write_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !strobe.pageWrite);

  // R3
  run_needs_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == REC_RUN) |-> cfgValid);

  // R2
  cfg_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfgLoad || state == REC_RUN) |=> $stable(cfgErr));

endmodule

// File: rtl/recbuf_dp.sv
module recbuf_dp
  import recbuf_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_SHIFT = 13,
  parameter int SSN_W      = 48
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  recStrobe_t                   strobe,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] cfgStartPage,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] cfgEndPage,
  input  logic [SSN_W-1:0]             sampleSsn,
  output logic                         pageReq,
  output logic [ADDR_W-1:0]            pageAddr,
  output logic [SSN_W-1:0]             pageSsn,
  output logic [ADDR_W-1:0]            newestAddr,
  output logic [SSN_W-1:0]             newestSsn,
  output logic [ADDR_W-1:0]            oldestAddr,
  output logic                         wrapped
);

  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

  logic [PAGE_W-1:0] startPage, endPage, curPage, nextPage;
  logic              atEnd;

  assign atEnd    = (curPage == endPage);
  assign nextPage = atEnd ? startPage : curPage + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      startPage  <= '0;
      endPage    <= '0;
      curPage    <= '0;
      wrapped    <= 1'b0;
      pageReq    <= 1'b0;
      pageAddr   <= '0;
      pageSsn    <= '0;
      newestAddr <= '0;
      newestSsn  <= '0;
    end else begin
      pageReq <= strobe.pageWrite;
      if (strobe.loadCfg) begin
        startPage <= cfgStartPage;
        endPage   <= cfgEndPage;
        curPage   <= cfgStartPage;
        wrapped   <= 1'b0;
      end else if (strobe.restart) begin
        curPage <= startPage;
        wrapped <= 1'b0;
      end else if (strobe.pageWrite) begin
        pageAddr   <= {curPage, {PAGE_SHIFT{1'b0}}};
        pageSsn    <= sampleSsn;
        newestAddr <= {curPage, {PAGE_SHIFT{1'b0}}};
        newestSsn  <= sampleSsn;
        curPage    <= nextPage;
        if (atEnd) wrapped <= 1'b1;
      end
    end
  end

  assign oldestAddr = {(wrapped ? curPage : startPage), {PAGE_SHIFT{1'b0}}};

  // R4
  page_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pageReq |-> (pageAddr[ADDR_W-1:PAGE_SHIFT] >= startPage &&
                 pageAddr[ADDR_W-1:PAGE_SHIFT] <= endPage));

  // R4
  page_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pageReq |-> (pageAddr[PAGE_SHIFT-1:0] == '0));

  // R5
  wrap_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrapped) |-> (curPage == startPage));

endmodule

// File: rtl/recbuf_recorder.sv
module recbuf_recorder
  import recbuf_pkg::*;
#(
  parameter int ADDR_W           = 24,
  parameter int PAGE_BYTES       = 8192,
  parameter int SAMPLES_PER_PAGE = 4,
  parameter int SSN_W            = 48,
  parameter int INPUT_INDEX      = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              procEnable,
  input  logic              cfgLoad,
  input  logic [ADDR_W-1:0] cfgStartAddr,
  input  logic [ADDR_W-1:0] cfgEndAddr,
  input  logic              freezeCmd,
  input  logic              unfreezeCmd,
  input  logic              readBusy,
  input  logic              sampleValid,
  input  logic [SSN_W-1:0]  sampleSsn,
  output logic              pageReq,
  output logic [ADDR_W-1:0] pageAddr,
  output logic [SSN_W-1:0]  pageSsn,
  output logic [ADDR_W-1:0] newestAddr,
  output logic [SSN_W-1:0]  newestSsn,
  output logic [ADDR_W-1:0] oldestAddr,
  output logic              stRecording,
  output logic              stFrozen,
  output logic              stReading,
  output logic              stWrapped,
  output logic              stCfgErr,
  output logic [7:0]        stInputIdx
);

  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
  localparam int ALIGN_W    = $clog2(SAMPLES_PER_PAGE);

  recStrobe_t strobe;

  recbuf_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .ALIGN_W(ALIGN_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .procEnable(procEnable),
    .cfgLoad(cfgLoad), .cfgStartAddr(cfgStartAddr), .cfgEndAddr(cfgEndAddr),
    .freezeCmd(freezeCmd), .unfreezeCmd(unfreezeCmd),
    .sampleValid(sampleValid), .sampleSsnLow(sampleSsn[ALIGN_W-1:0]),
    .strobe(strobe), .recording(stRecording), .frozen(stFrozen),
    .cfgErr(stCfgErr)
  );

  recbuf_dp #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .SSN_W(SSN_W)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .cfgStartPage(cfgStartAddr[ADDR_W-1:PAGE_SHIFT]),
    .cfgEndPage(cfgEndAddr[ADDR_W-1:PAGE_SHIFT]),
    .sampleSsn(sampleSsn),
    .pageReq(pageReq), .pageAddr(pageAddr), .pageSsn(pageSsn),
    .newestAddr(newestAddr), .newestSsn(newestSsn),
    .oldestAddr(oldestAddr), .wrapped(stWrapped)
  );

  assign stReading  = stFrozen && readBusy;
  assign stInputIdx = 8'(INPUT_INDEX);

  // R9
  reading_needs_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stReading |-> (stFrozen && !stRecording));

endmodule

// File: tb/test_recbuf_recorder.sv
module test_recbuf_recorder;

  localparam int ADDR_W = 24;
  localparam int SSN_W  = 48;
  localparam int SHIFT  = 13;
  localparam int IDX    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic procEnable = 0, cfgLoad = 0, freezeCmd = 0, unfreezeCmd = 0;
  logic readBusy = 0, sampleValid = 0;
  logic [ADDR_W-1:0] cfgStartAddr = '0, cfgEndAddr = '0;
  logic [SSN_W-1:0]  sampleSsn = '0;
  logic pageReq, stRecording, stFrozen, stReading, stWrapped, stCfgErr;
  logic [ADDR_W-1:0] pageAddr, newestAddr, oldestAddr;
  logic [SSN_W-1:0]  pageSsn, newestSsn;
  logic [7:0]        stInputIdx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [SSN_W-1:0] ssnCnt = '0;

  always #2.5 clk = ~clk;

  recbuf_recorder #(.ADDR_W(ADDR_W), .SSN_W(SSN_W), .INPUT_INDEX(IDX)) i_recbuf_recorder (
    .clk(clk), .rst_n(rst_n), .procEnable(procEnable), .cfgLoad(cfgLoad),
    .cfgStartAddr(cfgStartAddr), .cfgEndAddr(cfgEndAddr),
    .freezeCmd(freezeCmd), .unfreezeCmd(unfreezeCmd), .readBusy(readBusy),
    .sampleValid(sampleValid), .sampleSsn(sampleSsn),
    .pageReq(pageReq), .pageAddr(pageAddr), .pageSsn(pageSsn),
    .newestAddr(newestAddr), .newestSsn(newestSsn), .oldestAddr(oldestAddr),
    .stRecording(stRecording), .stFrozen(stFrozen), .stReading(stReading),
    .stWrapped(stWrapped), .stCfgErr(stCfgErr), .stInputIdx(stInputIdx)
  );

  // reference model, updated from the requirements at each rising edge
  bit mRun, mFrozen, mCfgValid, mCfgErr, mWrapped, mReq;
  int mStart, mEnd, mCur;
  logic [ADDR_W-1:0] mAddr, mNewA;
  logic [SSN_W-1:0]  mSsn, mNewS;

  function automatic bit cfgGood(logic [ADDR_W-1:0] s, logic [ADDR_W-1:0] e);
    return (s[SHIFT-1:0] == 0) && (e[SHIFT-1:0] == 0) && (e >= s);
  endfunction

  function automatic logic [ADDR_W-1:0] pageToAddr(int p);
    return ADDR_W'(p) << SHIFT;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mRun = 0; mFrozen = 0; mCfgValid = 0; mCfgErr = 0; mWrapped = 0; mReq = 0;
      mStart = 0; mEnd = 0; mCur = 0; mAddr = '0; mNewA = '0; mSsn = '0; mNewS = '0;
    end else begin
      mReq = 0;
      if (!mRun) begin
        if (cfgLoad) begin
          if (cfgGood(cfgStartAddr, cfgEndAddr)) begin
            mStart = int'(cfgStartAddr >> SHIFT); mEnd = int'(cfgEndAddr >> SHIFT);
            mCur = mStart; mWrapped = 0; mCfgValid = 1; mCfgErr = 0;
          end else mCfgErr = 1;
        end
        if (freezeCmd) mFrozen = 1;
        else if (unfreezeCmd) mFrozen = 0;
        else if (!mFrozen && mCfgValid && procEnable && !cfgLoad) begin
          mRun = 1; mCur = mStart; mWrapped = 0;
        end
      end else begin
        if (freezeCmd) begin mRun = 0; mFrozen = 1; end
        else if (!procEnable) mRun = 0;
        else if (sampleValid && sampleSsn[1:0] == 2'b00) begin
          mReq = 1; mAddr = pageToAddr(mCur); mSsn = sampleSsn;
          mNewA = mAddr; mNewS = sampleSsn;
          if (mCur == mEnd) begin mCur = mStart; mWrapped = 1; end
          else mCur = mCur + 1;
        end
      end
    end
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R4", "pageReq", 64'(pageReq), 64'(mReq));
    check("R4", "pageAddr", 64'(pageAddr), 64'(mAddr));
    check("R4", "pageSsn", 64'(pageSsn), 64'(mSsn));
    check("R3", "stRecording", 64'(stRecording), 64'(mRun));
    check("R6", "stFrozen", 64'(stFrozen), 64'(mFrozen));
    check("R5", "stWrapped", 64'(stWrapped), 64'(mWrapped));
    check("R2", "stCfgErr", 64'(stCfgErr), 64'(mCfgErr));
    check("R7", "newestAddr", 64'(newestAddr), 64'(mNewA));
    check("R7", "newestSsn", 64'(newestSsn), 64'(mNewS));
    check("R7", "oldestAddr", 64'(oldestAddr),
          64'(pageToAddr(mWrapped ? mCur : mStart)));
    check("R9", "stReading", 64'(stReading), 64'(mFrozen && readBusy));
    check("R9", "stInputIdx", 64'(stInputIdx), 64'(IDX));
  endtask

  // one clock: inputs already set; compare after the edge, then advance SSN
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    if (sampleValid) ssnCnt = ssnCnt + 1;
    sampleSsn = ssnCnt;
  endtask

  task automatic clearPulses();
    cfgLoad = 0; freezeCmd = 0; unfreezeCmd = 0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1: reset state
    check("R1", "rst pageReq", 64'(pageReq), 0);
    check("R1", "rst recording", 64'(stRecording), 0);
    check("R1", "rst frozen", 64'(stFrozen), 0);
    check("R1", "rst cfgErr", 64'(stCfgErr), 0);
    check("R1", "rst wrapped", 64'(stWrapped), 0);
    check("R1", "rst idx", 64'(stInputIdx), IDX);

    // R3: no window yet, procEnable must not start recording
    procEnable = 1; tick(); tick();
    check("R3", "no cfg no record", 64'(stRecording), 0);
    procEnable = 0;

    // R2: misaligned and reversed windows rejected
    cfgStartAddr = 24'h004010; cfgEndAddr = 24'h008000; cfgLoad = 1; tick(); clearPulses();
    check("R2", "misaligned err", 64'(stCfgErr), 1);
    cfgStartAddr = 24'h008000; cfgEndAddr = 24'h004000; cfgLoad = 1; tick(); clearPulses();
    check("R2", "reversed err", 64'(stCfgErr), 1);
    // good window pages 2..4
    cfgStartAddr = 24'h004000; cfgEndAddr = 24'h008000; cfgLoad = 1; tick(); clearPulses();
    check("R2", "good clears err", 64'(stCfgErr), 0);

    // R4/R5: record and wrap twice with a continuous stream
    procEnable = 1; tick();
    check("R3", "record entered", 64'(stRecording), 1);
    sampleValid = 1;
    for (int i = 0; i < 30; i++) begin
      if (pageReq && i < 4)
        check("R4", "first page is start", 64'(pageAddr), 64'h4000);
      tick();
    end
    check("R5", "wrapped after pass", 64'(stWrapped), 1);
    // R2: load during record ignored
    cfgStartAddr = 24'h100010; cfgLoad = 1; tick(); clearPulses();
    check("R2", "load in record ignored", 64'(stCfgErr), 0);

    // R6: freeze on a page-start sample
    while (sampleSsn[1:0] != 2'b00) tick();
    freezeCmd = 1; tick(); clearPulses();
    check("R6", "freeze beats page", 64'(pageReq), 0);
    check("R6", "frozen", 64'(stFrozen), 1);
    repeat (8) tick();
    check("R6", "no record frozen", 64'(stRecording), 0);
    readBusy = 1; tick();
    check("R9", "reading", 64'(stReading), 1);
    readBusy = 0;

    // R8: unfreeze with new window, resume at its start
    cfgStartAddr = 24'h00A000; cfgEndAddr = 24'h00A000; cfgLoad = 1; unfreezeCmd = 1;
    tick(); clearPulses();
    check("R8", "unfrozen", 64'(stFrozen), 0);
    for (int i = 0; i < 12; i++) begin
      tick();
      if (pageReq) check("R8", "resume page", 64'(pageAddr), 64'hA000);
    end

    // random phase
    for (int i = 0; i < 6000; i++) begin
      clearPulses();
      sampleValid = ($urandom_range(3) != 0);
      if ($urandom_range(199) == 0) procEnable = ~procEnable;
      if ($urandom_range(149) == 0) freezeCmd = 1;
      if ($urandom_range(59) == 0) unfreezeCmd = 1;
      readBusy = $urandom_range(1);
      if ($urandom_range(99) == 0) begin
        int s = $urandom_range(15);
        int e = s + $urandom_range(5);
        cfgStartAddr = pageToAddr(s);
        cfgEndAddr = pageToAddr(e);
        case ($urandom_range(3))
          0: cfgEndAddr = cfgEndAddr + 24'h40;
          1: begin cfgStartAddr = pageToAddr(e + 1); end
          default: ;
        endcase
        cfgLoad = 1;
      end
      tick();
    end
    finishRun();
  end

endmodule